// File: doc/BRIEF.md
# Weight-Stationary Matrix-Vector Array

This block is a grid of multiply-accumulate cells with `NUM_IN` rows and `NUM_OUT` columns. It multiplies a resident weight matrix by a stream of input vectors. Each cell keeps one signed weight in a local register. Activations travel rightward along the rows and partial sums travel downward along the columns, one cell per clock. The sums leave at the bottom edge as one result element per column. Because the weights stay in place, every vector reuses the whole matrix: `NUM_IN*NUM_OUT` products are formed per vector, while only `NUM_IN` activations enter and `NUM_OUT` sums leave.

Weights enter through a narrow shift path. Each load cycle pushes one column of `NUM_IN` weights into the leftmost column of cells, and every stored weight moves one column to the right. After `NUM_OUT` load cycles the matrix is complete. A vector presented on a cycle is captured whole. The block delays it internally so that row `i` starts `i` cycles later. Results leave staggered by column, and each column has its own valid flag. The user must let in-flight vectors drain before starting a new weight load. Sums are kept at a width that cannot overflow for any input.

Top module: `ws_matvec_array`

## Requirements
- R1: After reset every stored weight, partial sum and valid flag is zero. A vector sent before any load therefore produces an all-zero result, with its valid flags raised.
- R2: On every clock edge with `loadEn` high, the row-i lane of `wgtIn` (bits `i*WGT_W +: WGT_W`) enters column 0 of row i, and each stored weight moves from column k to column k+1. The weight in the last column is discarded. After the last `NUM_OUT` load edges, the n-th of them (n = 1..NUM_OUT) has filled column `NUM_OUT-n`.
- R3: While `loadEn` is low the weights do not change, and the same matrix is applied to every vector that follows.
- R4: For an accepted vector x, with element i at `vecIn` bits `i*ACT_W +: ACT_W`, result element k is placed on `outData` bits `k*ACC_W +: ACC_W`. Its value is the sum over i of W[i][k]*x[i], with all values signed two's complement.
- R5: `ACC_W` equals `ACT_W+WGT_W+clog2(NUM_IN)`. Every sum, including the extremes reached with all operands at the most negative code, is represented exactly and sign-extended.
- R6: A vector is accepted on an edge where `vecValid` is high and `loadEn` is low. Result element k is presented for exactly one cycle, following the edge `NUM_IN-1+k` edges after acceptance, with `outValid[k]` high. Each valid pulse on column k is followed by one on column k+1 on the next cycle.
- R7: A new vector can be accepted on every edge, and back-to-back vectors produce back-to-back results on each column.
- R8: A vector presented while `loadEn` is high is ignored and raises no valid flag on any column.
- R9: Whenever `outValid[k]` is low, result lane k reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| loadEn | input | 1 | Shift one weight column into the array this cycle |
| wgtIn | input | NUM_IN*WGT_W | One weight per row for the column being shifted in |
| vecValid | input | 1 | Input vector present |
| vecIn | input | NUM_IN*ACT_W | Input vector, one activation per row |
| outValid | output | NUM_OUT | Per-column result valid, staggered by one cycle per column |
| outData | output | NUM_OUT*ACC_W | Per-column signed result |

## Verification
Several properties are checked on every cycle:
- The accumulation never loses a carry.
- Weights hold still whenever no load is under way.
- A load cycle never starts a vector down the valid pipeline.
- Idle result lanes read zero.
- Each column's valid pulse is followed by the next column's pulse one cycle later.

The product values themselves are shown only by the bench scenarios. These are the load ordering of columns, the result of a load with one column too many, the input skew, and the exact timing from acceptance to result. The bench compares every cycle against a behavioural model fed with random matrices, back-to-back and gapped vectors, extreme operands, and vectors offered during a load.

// File: rtl/sa_pkg.sv
package sa_pkg;
  // Strobes from the control block to the datapath
  typedef struct packed {
    logic shiftWgt;   // move the weight chain one column
    logic acceptVec;  // capture the presented vector
  } saStrobe_t;
endpackage

// File: rtl/ws_mac_cell.sv
module ws_mac_cell #(
  parameter int ACT_W = 4,
  parameter int WGT_W = 4,
  parameter int ACC_W = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WGT_W-1:0] wgt,
  input  logic [ACT_W-1:0] act,
  input  logic [ACC_W-1:0] psumIn,
  output logic [ACC_W-1:0] psumOut
);
  localparam int PW = ACT_W + WGT_W;

  logic signed [PW-1:0]  wExt;
  logic signed [PW-1:0]  aExt;
  logic signed [PW-1:0]  product;
  logic signed [ACC_W:0] sumWide;

  assign wExt    = PW'($signed(wgt));
  assign aExt    = PW'($signed(act));
  assign product = wExt * aExt;
  assign sumWide = (ACC_W+1)'($signed(psumIn)) + (ACC_W+1)'(product);

  always_ff @(posedge clk) begin
    if (!rstN) psumOut <= '0;
    else       psumOut <= sumWide[ACC_W-1:0];
  end

  // R5: the extra guard bit must always match the sign bit
  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rstN)
    sumWide[ACC_W] == sumWide[ACC_W-1]);
endmodule

// File: rtl/ws_datapath.sv
module ws_datapath
  import sa_pkg::*;
#(
  parameter int NUM_IN  = 4,
  parameter int NUM_OUT = 3,
  parameter int ACT_W   = 4,
  parameter int WGT_W   = 4,
  parameter int ACC_W   = 10
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  saStrobe_t                strobe,
  input  logic [NUM_IN*WGT_W-1:0]  wgtIn,
  input  logic [NUM_IN*ACT_W-1:0]  vecIn,
  output logic [NUM_OUT*ACC_W-1:0] psumOut
);
  localparam int HOPS = (NUM_OUT > 1) ? NUM_OUT - 1 : 1;

  logic [WGT_W-1:0] wgtGrid [NUM_IN][NUM_OUT];
  logic [ACT_W-1:0] actHead [NUM_IN];
  logic [ACT_W-1:0] actHop  [NUM_IN][HOPS];
  logic [ACC_W-1:0] psumW   [NUM_IN+1][NUM_OUT];

  // Weight daisy chain: column 0 takes the port, others take their left neighbour
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_IN; i++)
        for (int k = 0; k < NUM_OUT; k++) wgtGrid[i][k] <= '0;
    end else if (strobe.shiftWgt) begin
      for (int i = 0; i < NUM_IN; i++) begin
        wgtGrid[i][0] <= wgtIn[i*WGT_W +: WGT_W];
        for (int k = 1; k < NUM_OUT; k++) wgtGrid[i][k] <= wgtGrid[i][k-1];
      end
    end
  end

  // Input skew: row i sees its element i cycles after capture
  for (genvar i = 0; i < NUM_IN; i++) begin : g_skew
    logic [ACT_W-1:0] gated;
    assign gated = strobe.acceptVec ? vecIn[i*ACT_W +: ACT_W] : '0;
    if (i == 0) begin : g_direct
      assign actHead[i] = gated;
    end else begin : g_delay
      logic [ACT_W-1:0] dly [i];
      always_ff @(posedge clk) begin
        if (!rstN) begin
          for (int d = 0; d < i; d++) dly[d] <= '0;
        end else begin
          dly[0] <= gated;
          for (int d = 1; d < i; d++) dly[d] <= dly[d-1];
        end
      end
      assign actHead[i] = dly[i-1];
    end
  end

  // Activation hops between neighbouring columns
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_IN; i++)
        for (int h = 0; h < HOPS; h++) actHop[i][h] <= '0;
    end else begin
      for (int i = 0; i < NUM_IN; i++) begin
        actHop[i][0] <= actHead[i];
        for (int h = 1; h < HOPS; h++) actHop[i][h] <= actHop[i][h-1];
      end
    end
  end

  for (genvar k = 0; k < NUM_OUT; k++) begin : g_col
    assign psumW[0][k] = '0;
    for (genvar i = 0; i < NUM_IN; i++) begin : g_row
      logic [ACT_W-1:0] cellAct;
      if (k == 0) begin : g_first
        assign cellAct = actHead[i];
      end else begin : g_rest
        assign cellAct = actHop[i][k-1];
      end
      ws_mac_cell #(.ACT_W(ACT_W), .WGT_W(WGT_W), .ACC_W(ACC_W)) u_cell (
        .clk    (clk),
        .rstN   (rstN),
        .wgt    (wgtGrid[i][k]),
        .act    (cellAct),
        .psumIn (psumW[i][k]),
        .psumOut(psumW[i+1][k])
      );
      // R3: a resident weight only moves on a shift strobe
      assert_weight_held_R3: assert property (@(posedge clk) disable iff (!rstN)
        !strobe.shiftWgt |=> $stable(wgtGrid[i][k]));
    end
    assign psumOut[k*ACC_W +: ACC_W] = psumW[NUM_IN][k];
  end
endmodule

// File: rtl/ws_control.sv
module ws_control
  import sa_pkg::*;
#(
  parameter int NUM_IN  = 4,
  parameter int NUM_OUT = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               loadEn,
  input  logic               vecValid,
  output saStrobe_t          strobe,
  output logic [NUM_OUT-1:0] outValid
);
  localparam int VLEN = NUM_IN + NUM_OUT - 1;

  logic [VLEN-1:0] validSr;

  always_comb begin
    strobe.shiftWgt  = loadEn;
    strobe.acceptVec = vecValid & ~loadEn;
  end

  // Valid token follows the wavefront of each accepted vector
  always_ff @(posedge clk) begin
    if (!rstN) begin
      validSr <= '0;
    end else begin
      validSr[0] <= strobe.acceptVec;
      for (int j = 1; j < VLEN; j++) validSr[j] <= validSr[j-1];
    end
  end

  for (genvar k = 0; k < NUM_OUT; k++) begin : g_valid
    assign outValid[k] = validSr[NUM_IN-1+k];
  end

  // R8: a load cycle never launches a vector
  assert_load_blocks_vec_R8: assert property (@(posedge clk) disable iff (!rstN)
    loadEn |=> !validSr[0]);
endmodule

// File: rtl/ws_matvec_array.sv
module ws_matvec_array
  import sa_pkg::*;
#(
  parameter int NUM_IN  = 4,
  parameter int NUM_OUT = 3,
  parameter int ACT_W   = 4,
  parameter int WGT_W   = 4,
  localparam int ACC_W  = ACT_W + WGT_W + $clog2(NUM_IN)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     loadEn,
  input  logic [NUM_IN*WGT_W-1:0]  wgtIn,
  input  logic                     vecValid,
  input  logic [NUM_IN*ACT_W-1:0]  vecIn,
  output logic [NUM_OUT-1:0]       outValid,
  output logic [NUM_OUT*ACC_W-1:0] outData
);
  saStrobe_t strobe;

  ws_control #(.NUM_IN(NUM_IN), .NUM_OUT(NUM_OUT)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .loadEn  (loadEn),
    .vecValid(vecValid),
    .strobe  (strobe),
    .outValid(outValid)
  );

  ws_datapath #(
    .NUM_IN(NUM_IN), .NUM_OUT(NUM_OUT),
    .ACT_W(ACT_W), .WGT_W(WGT_W), .ACC_W(ACC_W)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .wgtIn  (wgtIn),
    .vecIn  (vecIn),
    .psumOut(outData)
  );

  for (genvar k = 0; k < NUM_OUT; k++) begin : g_chk
    // R9: idle lanes carry zero
    assert_idle_zero_R9: assert property (@(posedge clk) disable iff (!rstN)
      !outValid[k] |-> (outData[k*ACC_W +: ACC_W] == '0));
    if (k < NUM_OUT - 1) begin : g_step
      // R6: results stagger by one cycle per column
      assert_skew_step_R6: assert property (@(posedge clk) disable iff (!rstN)
        outValid[k] |=> outValid[k+1]);
    end
  end
endmodule

// File: tb/test_ws_matvec_array.sv
`timescale 1ns/1ps
module test_ws_matvec_array;
  localparam int NI = 4;
  localparam int NO = 3;
  localparam int AW = 4;
  localparam int WW = 4;
  localparam int AC = AW + WW + $clog2(NI);

  logic              clk = 0;
  logic              rstN = 0;
  logic              loadEn = 0;
  logic [NI*WW-1:0]  wgtIn = '0;
  logic              vecValid = 0;
  logic [NI*AW-1:0]  vecIn = '0;
  logic [NO-1:0]     outValid;
  logic [NO*AC-1:0]  outData;

  ws_matvec_array #(.NUM_IN(NI), .NUM_OUT(NO), .ACT_W(AW), .WGT_W(WW)) i_ws_matvec_array (
    .clk(clk), .rstN(rstN), .loadEn(loadEn), .wgtIn(wgtIn),
    .vecValid(vecValid), .vecIn(vecIn), .outValid(outValid), .outData(outData)
  );

  always #2.5 clk = ~clk;

  int    cyc = 0;
  int    tests = 0;
  int    fails = 0;
  bit    checking = 0;
  bit    finished = 0;
  string curReq = "R1";

  logic [WW-1:0] mw [NI][NO];
  int dueQ [NO][$];
  int valQ [NO][$];

  always @(posedge clk) cyc <= cyc + 1;

  // Per-cycle comparison against the behavioural model
  always @(negedge clk) begin
    int got;
    if (checking) begin
      for (int k = 0; k < NO; k++) begin
        got = int'($signed(outData[k*AC +: AC]));
        if (dueQ[k].size() > 0 && dueQ[k][0] == cyc) begin
          tests++;
          if (!outValid[k] || got != valQ[k][0]) begin
            fails++;
            $display("FAIL %s/R4/R6 col %0d cyc %0d: valid=%0b data=%0d expected valid=1 data=%0d",
                     curReq, k, cyc, outValid[k], got, valQ[k][0]);
          end
          void'(dueQ[k].pop_front());
          void'(valQ[k].pop_front());
        end else begin
          tests++;
          if (outValid[k]) begin
            fails++;
            $display("FAIL %s/R6/R8 col %0d cyc %0d: valid=1 expected valid=0", curReq, k, cyc);
          end
          tests++;
          if (got != 0) begin
            fails++;
            $display("FAIL %s/R9 col %0d cyc %0d: data=%0d expected 0", curReq, k, cyc, got);
          end
        end
      end
    end
  end

  task automatic gap(input int n);
    for (int c = 0; c < n; c++) begin
      @(negedge clk);
      loadEn = 0; vecValid = 0; vecIn = '0;
    end
  endtask

  task automatic loadCol(input logic [NI*WW-1:0] lanes, input bit offerVec);
    @(negedge clk);
    loadEn = 1; wgtIn = lanes; vecValid = offerVec;
    vecIn = NI*AW'($urandom);
    for (int i = 0; i < NI; i++) begin
      for (int k = NO-1; k > 0; k--) mw[i][k] = mw[i][k-1];
      mw[i][0] = lanes[i*WW +: WW];
    end
  endtask

  task automatic sendVec(input logic [NI*AW-1:0] v);
    int s;
    @(negedge clk);
    loadEn = 0; vecValid = 1; vecIn = v;
    for (int k = 0; k < NO; k++) begin
      s = 0;
      for (int i = 0; i < NI; i++)
        s += int'($signed(mw[i][k])) * int'($signed(v[i*AW +: AW]));
      dueQ[k].push_back(cyc + NI + k);
      valQ[k].push_back(s);
    end
  endtask

  function automatic logic [NI*AW-1:0] rndVec();
    logic [NI*AW-1:0] r;
    for (int i = 0; i < NI; i++) r[i*AW +: AW] = AW'($urandom_range(0, 15));
    return r;
  endfunction

  function automatic logic [NI*WW-1:0] rndCol();
    logic [NI*WW-1:0] r;
    for (int i = 0; i < NI; i++) r[i*WW +: WW] = WW'($urandom_range(0, 15));
    return r;
  endfunction

  initial begin
    for (int i = 0; i < NI; i++)
      for (int k = 0; k < NO; k++) mw[i][k] = '0;
    repeat (3) @(negedge clk);
    // R1: outputs idle while in reset
    tests++;
    if (outValid != '0) begin
      fails++; $display("FAIL R1 reset valid=%b expected 0", outValid);
    end
    tests++;
    if (outData != '0) begin
      fails++; $display("FAIL R1 reset data=%h expected 0", outData);
    end
    rstN = 1;
    checking = 1;

    // R1: zero weights give zero sums with valid raised
    curReq = "R1";
    sendVec(rndVec());
    gap(NI + NO + 2);

    // R2 + R7: full load, then back-to-back vectors
    curReq = "R2/R7";
    for (int n = 0; n < NO; n++) loadCol(rndCol(), 1'b0);
    for (int v = 0; v < 6; v++) sendVec(rndVec());
    gap(NI + NO + 2);

    // R3: weights kept across idle time and gapped vectors
    curReq = "R3";
    gap(7);
    for (int v = 0; v < 3; v++) begin
      sendVec(rndVec());
      gap(v + 1);
    end
    gap(NI + NO + 2);

    // R5: extreme operands
    curReq = "R5";
    for (int n = 0; n < NO; n++) loadCol({NI{4'h8}}, 1'b0);
    sendVec({NI{4'h8}});
    sendVec({NI{4'h7}});
    sendVec({NI{4'h8}});
    gap(NI + NO + 2);

    // R8 + R2: vectors offered during a load with one extra column are dropped
    curReq = "R8/R2";
    for (int n = 0; n < NO + 1; n++) loadCol(rndCol(), 1'b1);
    for (int v = 0; v < 4; v++) sendVec(rndVec());
    gap(NI + NO + 4);

    // R6: every scheduled result must have appeared
    for (int k = 0; k < NO; k++) begin
      tests++;
      if (dueQ[k].size() != 0) begin
        fails++;
        $display("FAIL R6 col %0d pending=%0d expected 0", k, dueQ[k].size());
      end
    end

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  always @(posedge clk) begin
    if (!finished && cyc > 20000) begin
      fails++;
      $display("FAIL R6 watchdog: cycle %0d expected below 20000", cyc);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule